// File: doc/BRIEF.md
# Masked Pattern Detector with Automatic Accumulator Clear

This block holds the output register of a wide accumulator and watches every value loaded into it. Before comparing, it ignores any bit positions that the mask marks. It compares the remaining bits against a pattern and, separately, against the bitwise inverse of that pattern. The pattern and the mask are chosen independently. Each can be a fixed parameter or the live value on the side input `c_in`. Both detection flags are registered together with the accumulator register, so each flag always describes the value currently shown on `p_q`.

A mask whose ones fill the low N bits, used with an all-zero pattern, turns the two flags into a range monitor. The match flag means the value still fits in [0, 2^N). The inverse flag means it still fits in [-2^N, 0). The block keeps the previous state of both flags. From that history it reports a value that has just climbed out of the positive range as overflow, and a value that has just fallen out of the negative range as underflow.

The block can also clear the accumulator register automatically on the edge that follows a match. A priority parameter sets how this interacts with the register's load enable. In one setting the clear always happens. In the other it waits until the enable is active.

Top module: `pattern_watch`

## Requirements
- R1: `pat_hit` is 1 exactly when the value held in `p_q` equals the pattern in every bit position where the mask bit is 0. Positions whose mask bit is 1 are ignored. The flag updates on the same edge that loads `p_q`.
- R2: `patb_hit` is 1 exactly when the value held in `p_q` equals the bitwise inverse of the pattern in every bit position whose mask bit is 0. It updates on the same edge as `p_q`.
- R3: With `PAT_SRC`=0 the pattern is the parameter `PATTERN`. With `PAT_SRC`=1 it is the value on `c_in` at the loading edge.
- R4: With `MASK_SRC`=0 the mask is the parameter `MASK`. With `MASK_SRC`=1 it is the value on `c_in` at the loading edge.
- R5: `ovf` is 1 when both of these hold: `pat_hit` was 1 before the most recent load, and both `pat_hit` and `patb_hit` are 0 after it.
- R6: `unf` is 1 when both of these hold: `patb_hit` was 1 before the most recent load, and both `pat_hit` and `patb_hit` are 0 after it.
- R7: With `AUTO_CLR`=1 and `CLR_PRIO`=0, a clock edge that sees `pat_hit`=1 clears `p_q`, both detection flags and the flag history, whatever the state of `p_en`. After the clear, `ovf` and `unf` read 0.
- R8: With `AUTO_CLR`=1 and `CLR_PRIO`=1, a pending clear takes effect only on an edge where `p_en` is 1. While `p_en` is 0, `p_q` and `pat_hit` hold.
- R9: With `AUTO_CLR`=0, a match never clears `p_q`. The next enabled edge loads `acc_in` as usual.
- R10: On an edge with `p_en`=0 and no automatic clear taking effect, `p_q`, `pat_hit` and `patb_hit` keep their values.
- R11: A synchronous `rst`=1 edge clears `p_q`, both flags and the flag history, so `ovf` and `unf` read 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| p_en | input | 1 | Load enable of the accumulator register |
| acc_in | input | W | Next accumulator value (adder output) |
| c_in | input | W | Side input; can supply the pattern or the mask |
| p_q | output | W | Accumulator register |
| pat_hit | output | 1 | Masked match against the pattern |
| patb_hit | output | 1 | Masked match against the inverted pattern |
| ovf | output | 1 | Value has just left the positive range |
| unf | output | 1 | Value has just left the negative range |

## Verification
The flag history is the state most likely to go wrong. A stale or uncleared history bit shows up on the ports as a spurious `ovf` or `unf` on the very first enabled load after a reset or an automatic clear. The bench therefore checks both flags directly after each kind of clear. A pending clear that is mishandled shows up one edge later as `p_q` failing to read zero, or reading zero too early under the enable-gated priority. The bench checks `p_q` on each of the edges around the match. A wrong mask or pattern source changes `pat_hit` on the same edge that loads the value, so every range crossing is checked on that edge.

// File: rtl/pattern_watch.sv
module pattern_watch #(
  parameter int              W        = 58,
  parameter bit              PAT_SRC  = 1'b0,
  parameter bit              MASK_SRC = 1'b0,
  parameter logic [W-1:0]    PATTERN  = '0,
  parameter logic [W-1:0]    MASK     = '0,
  parameter bit              AUTO_CLR = 1'b0,
  parameter bit              CLR_PRIO = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         p_en,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] p_q,
  output logic         pat_hit,
  output logic         patb_hit,
  output logic         ovf,
  output logic         unf
);

  logic [W-1:0] pat, msk, diff;
  logic         hit, hitb, clr_now, prev_hit, prev_hitb;

  assign pat  = PAT_SRC  ? c_in : PATTERN;
  assign msk  = MASK_SRC ? c_in : MASK;

  // one XOR layer serves both compares: zero => match, all ones => inverse match
  assign diff = (acc_in ^ pat) & ~msk;
  assign hit  = ~|diff;
  assign hitb = &(diff | msk);

  assign clr_now = AUTO_CLR && pat_hit && (!CLR_PRIO || p_en);

  always_ff @(posedge clk) begin
    if (rst || clr_now) begin
      p_q       <= '0;
      pat_hit   <= 1'b0;
      patb_hit  <= 1'b0;
      prev_hit  <= 1'b0;
      prev_hitb <= 1'b0;
    end else if (p_en) begin
      p_q       <= acc_in;
      pat_hit   <= hit;
      patb_hit  <= hitb;
      prev_hit  <= pat_hit;
      prev_hitb <= patb_hit;
    end
  end

  assign ovf = prev_hit  && !pat_hit && !patb_hit;
  assign unf = prev_hitb && !pat_hit && !patb_hit;

endmodule

// File: rtl/pattern_watch_chk.sv
module pattern_watch_chk #(
  parameter int           W        = 58,
  parameter bit           PAT_SRC  = 1'b0,
  parameter bit           MASK_SRC = 1'b0,
  parameter logic [W-1:0] PATTERN  = '0,
  parameter logic [W-1:0] MASK     = '0,
  parameter bit           AUTO_CLR = 1'b0,
  parameter bit           CLR_PRIO = 1'b0
) (
  input logic         clk,
  input logic         rst,
  input logic         p_en,
  input logic [W-1:0] p_q,
  input logic         pat_hit,
  input logic         patb_hit,
  input logic         ovf,
  input logic         unf
);

  localparam bit FIXED = !PAT_SRC && !MASK_SRC;

  a_r1_hit_matches_p: assert property (@(posedge clk) disable iff (rst)
    (FIXED && pat_hit) |-> (((p_q ^ PATTERN) & ~MASK) == '0));

  a_r2_hitb_matches_p: assert property (@(posedge clk) disable iff (rst)
    (FIXED && patb_hit) |-> (((p_q ^ ~PATTERN) & ~MASK) == '0));

  a_r6_no_ovf_and_unf: assert property (@(posedge clk) disable iff (rst)
    !(ovf && unf));

  a_r7_auto_clear: assert property (@(posedge clk) disable iff (rst)
    (AUTO_CLR && !CLR_PRIO && pat_hit) |=> (p_q == '0 && !ovf && !unf));

  a_r8_cep_wait: assert property (@(posedge clk) disable iff (rst)
    (AUTO_CLR && CLR_PRIO && pat_hit && !p_en) |=> ($stable(p_q) && pat_hit));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (!p_en && !(AUTO_CLR && pat_hit)) |=> ($stable(p_q) && $stable(pat_hit) && $stable(patb_hit)));

  a_r11_reset: assert property (@(posedge clk)
    rst |=> (p_q == '0 && !pat_hit && !patb_hit && !ovf && !unf));

endmodule

bind pattern_watch pattern_watch_chk #(
  .W(W), .PAT_SRC(PAT_SRC), .MASK_SRC(MASK_SRC), .PATTERN(PATTERN),
  .MASK(MASK), .AUTO_CLR(AUTO_CLR), .CLR_PRIO(CLR_PRIO)
) u_chk (
  .clk(clk), .rst(rst), .p_en(p_en), .p_q(p_q), .pat_hit(pat_hit),
  .patb_hit(patb_hit), .ovf(ovf), .unf(unf)
);

// File: tb/pattern_watch_tb.sv
module pattern_watch_tb;
  localparam int W = 58;
  localparam logic [W-1:0] M8 = 58'hFF;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic p_en = 1'b0;
  logic [W-1:0] acc_in = '0;
  logic [W-1:0] c_in = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  logic [W-1:0] q0, q1, q2, q3, q4;
  logic h0, h1, h2, h3, h4, b0, b1, b2, b3, b4;
  logic o0, o1, o2, o3, o4, u0, u1, u2, u3, u4;

  pattern_watch #(.W(W), .MASK(M8)) u_dut (
    .clk(clk), .rst(rst), .p_en(p_en), .acc_in(acc_in), .c_in(c_in),
    .p_q(q0), .pat_hit(h0), .patb_hit(b0), .ovf(o0), .unf(u0));
  pattern_watch #(.W(W), .MASK(M8), .AUTO_CLR(1'b1), .CLR_PRIO(1'b0)) u_rstp (
    .clk(clk), .rst(rst), .p_en(p_en), .acc_in(acc_in), .c_in(c_in),
    .p_q(q1), .pat_hit(h1), .patb_hit(b1), .ovf(o1), .unf(u1));
  pattern_watch #(.W(W), .MASK(M8), .AUTO_CLR(1'b1), .CLR_PRIO(1'b1)) u_cepp (
    .clk(clk), .rst(rst), .p_en(p_en), .acc_in(acc_in), .c_in(c_in),
    .p_q(q2), .pat_hit(h2), .patb_hit(b2), .ovf(o2), .unf(u2));
  pattern_watch #(.W(W), .PAT_SRC(1'b1), .MASK(M8)) u_cpat (
    .clk(clk), .rst(rst), .p_en(p_en), .acc_in(acc_in), .c_in(c_in),
    .p_q(q3), .pat_hit(h3), .patb_hit(b3), .ovf(o3), .unf(u3));
  pattern_watch #(.W(W), .MASK_SRC(1'b1)) u_cmsk (
    .clk(clk), .rst(rst), .p_en(p_en), .acc_in(acc_in), .c_in(c_in),
    .p_q(q4), .pat_hit(h4), .patb_hit(b4), .ovf(o4), .unf(u4));

  function automatic logic [W-1:0] neg(input int v);
    return '0 - W'(v);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [W-1:0] v, input logic en);
    acc_in = v;
    p_en = en;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc('0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    cyc(W'(100), 1'b1);
    do_reset();
    chk("R11 p_q", 64'(q0), 64'd0);
    chk("R11 pat_hit", 64'(h0), 64'd0);
    chk("R11 ovf", 64'(o0), 64'd0);
  endtask

  task automatic t_overflow();
    do_reset();
    cyc(W'(200), 1'b1);
    chk("R1 in range", 64'(h0), 64'd1);
    chk("R5 no ovf yet", 64'(o0), 64'd0);
    cyc(W'(300), 1'b1);
    chk("R1 out of range", 64'(h0), 64'd0);
    chk("R5 ovf", 64'(o0), 64'd1);
    chk("R6 no unf", 64'(u0), 64'd0);
    cyc(W'(400), 1'b1);
    chk("R5 ovf one load", 64'(o0), 64'd0);
  endtask

  task automatic t_underflow();
    do_reset();
    cyc(neg(1), 1'b1);
    chk("R2 minus one", 64'(b0), 64'd1);
    cyc(neg(200), 1'b1);
    chk("R2 in neg range", 64'(b0), 64'd1);
    chk("R6 no unf yet", 64'(u0), 64'd0);
    cyc(neg(300), 1'b1);
    chk("R6 unf", 64'(u0), 64'd1);
    chk("R5 no ovf", 64'(o0), 64'd0);
  endtask

  task automatic t_hold();
    do_reset();
    cyc(W'(50), 1'b1);
    cyc(W'(999), 1'b0);
    chk("R10 p_q held", 64'(q0), 64'd50);
    chk("R10 pat_hit held", 64'(h0), 64'd1);
    chk("R9 no auto clear", 64'(q0), 64'd50);
  endtask

  task automatic t_auto_reset_prio();
    do_reset();
    cyc(W'(10), 1'b1);
    chk("R7 loaded", 64'(q1), 64'd10);
    cyc(W'(500), 1'b0);
    chk("R7 cleared without enable", 64'(q1), 64'd0);
    chk("R7 flag cleared", 64'(h1), 64'd0);
    chk("R7 no ovf after clear", 64'(o1), 64'd0);
    cyc(W'(500), 1'b1);
    chk("R7 no ovf on next load", 64'(o1), 64'd0);
  endtask

  task automatic t_auto_cep_prio();
    do_reset();
    cyc(W'(10), 1'b1);
    cyc(W'(500), 1'b0);
    chk("R8 held while disabled", 64'(q2), 64'd10);
    chk("R8 flag held", 64'(h2), 64'd1);
    cyc(W'(500), 1'b1);
    chk("R8 cleared with enable", 64'(q2), 64'd0);
    chk("R9 plain loads", 64'(q0), 64'd500);
  endtask

  task automatic t_sources();
    do_reset();
    c_in = W'(58'h1200);
    cyc(W'(58'h12AB), 1'b1);
    chk("R3 pattern from c", 64'(h3), 64'd1);
    chk("R3 param pattern differs", 64'(h0), 64'd0);
    cyc(W'(58'h13AB), 1'b1);
    chk("R3 pattern from c miss", 64'(h3), 64'd0);
    c_in = W'(58'hFFFF);
    cyc(W'(58'h1234), 1'b1);
    chk("R4 mask from c", 64'(h4), 64'd1);
    c_in = W'(58'hFF);
    cyc(W'(58'h1234), 1'b1);
    chk("R4 narrow mask from c", 64'(h4), 64'd0);
    c_in = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #2;
    t_reset();
    t_overflow();
    t_underflow();
    t_hold();
    t_auto_reset_prio();
    t_auto_cep_prio();
    t_sources();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule